// File: doc/BRIEF.md
# Core-Module Control Register Bank

This block is the control and status register bank of a processor core module. A host reaches it over a plain 32-bit register bus. The bus carries a byte address, a write strobe, write data and combinational read data. The bank holds the oscillator settings, the memory configuration words and a control word. The control word drives two outputs: the selection of what is mapped at address zero after boot, and an indicator LED. The two oscillator words are protected by a 16-bit unlock key, so a stray write cannot retune the clocks.

The bank also carries two flag words. Each flag word has a set address and a clear address. A one-bit software interrupt source sits behind two independent enable masks, one for the normal interrupt and one for the fast interrupt. The combined request leaves the block on a single output. The upper half of the address space is a read-only window onto a module description table. The table is computed from the index, so no stored memory is needed.

Two small state machines carry the block's modal state. The key machine has the states `KEY_LOCKED` and `KEY_OPEN`. A write to the key word takes it to `KEY_OPEN` when the key matches (transition *unlock*), and to `KEY_LOCKED` for any other value (transition *relock*). The remap machine has the states `MAP_FLASH` and `MAP_RAM`. A control write with bit 2 set moves it to `MAP_RAM` (transition *to_ram*). A control write with bit 2 clear moves it to `MAP_FLASH` (transition *to_flash*). Other writes leave both machines where they are.

Top module: `cm_ctrl_bank`

## Requirements
- R1: The key word (byte 0x14) keeps only bits 15:0 of the write data. The bank is open only while the kept key equals 0xA05F. A read returns the key in bits 15:0 and a 1 in bit 16 while the bank is locked. After reset the key is 0 and the bank is locked, so the word reads 0x00010000.
- R2: Writes to the oscillator word (byte 0x04) and the auxiliary oscillator word (byte 0x1C) update them only while the bank is open. While the bank is locked these writes leave the words unchanged.
- R3: The reset values are: oscillator 0x01000048, auxiliary oscillator 0x0007FEFF, memory configuration (byte 0x20) 0x00011122, init (byte 0x24) 0x00000112, and control 0. The memory configuration and init words are freely writable.
- R4: The flag word reads at byte 0x30. A write to 0x30 ORs the data into it. A write to 0x34 clears the bits that are set in the data. Its reset value is 0.
- R5: The retained flag word reads at byte 0x38. It is set by writes to 0x38 and cleared by writes to 0x3C, with the same OR / AND-NOT behaviour as the flag word. It is independent of the flag word.
- R6: The control word (byte 0x0C) reads back as written. Bit 2 drives `remap_ram` (1 maps RAM at address zero, 0 maps boot flash). Bit 0 drives `led_on`. Both outputs change in the cycle after the write.
- R7: A byte address from 0x100 to 0x1FF reads the table entry at index i = address >> 2, zero-extended to 32 bits. The entry value is the low byte of (i × 37), XOR 0xC3. Writes to this window have no effect.
- R8: The interrupt level is a single bit. A write to byte 0x50 with data bit 0 set sets the level. A write to byte 0x54 with data bit 0 set clears it. Other data bits are ignored. Bytes 0x50, 0x44 and 0x64 read the level in bit 0.
- R9: The normal interrupt enable is set at byte 0x48, cleared at 0x4C and read at 0x48. Byte 0x40 reads level AND normal enable. The fast interrupt enable is set at byte 0x68, cleared at 0x6C and read at 0x68. Byte 0x60 reads level AND fast enable.
- R10: `core_irq` is high exactly when the level is set and bit 0 of either enable is set. It follows register changes in the cycle after the write.
- R11: Addresses below 0x100 with no register read as zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 9 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| remap_ram | output | 1 | 1 = RAM at address zero, 0 = boot flash |
| led_on | output | 1 | Indicator LED drive |
| core_irq | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that reset is held low through the first clock edge. They also assume that `bus_we`, `bus_addr` and `bus_wdata` are settled before each rising edge, since every write is sampled at that single edge. The stimulus drives all bus inputs on the falling edge and issues one single-cycle write at a time. Reads are sampled a moment after the address settles, with the write strobe low, so the combinational read path is never observed mid-write.

// File: rtl/cm_pkg.sv
package cm_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned KEY_W   = 16;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hA05F;

    // word indices (byte address >> 2)
    localparam int unsigned W_OSC      = 1;
    localparam int unsigned W_CTRL     = 3;
    localparam int unsigned W_KEY      = 5;
    localparam int unsigned W_AUX      = 7;
    localparam int unsigned W_MEMCFG   = 8;
    localparam int unsigned W_INIT     = 9;
    localparam int unsigned W_FLAG_SET = 12;
    localparam int unsigned W_FLAG_CLR = 13;
    localparam int unsigned W_NVF_SET  = 14;
    localparam int unsigned W_NVF_CLR  = 15;
    localparam int unsigned W_IRQ_STAT = 16;
    localparam int unsigned W_IRQ_RAW  = 17;
    localparam int unsigned W_IRQ_ENS  = 18;
    localparam int unsigned W_IRQ_ENC  = 19;
    localparam int unsigned W_LVL_SET  = 20;
    localparam int unsigned W_LVL_CLR  = 21;
    localparam int unsigned W_FIQ_STAT = 24;
    localparam int unsigned W_FIQ_RAW  = 25;
    localparam int unsigned W_FIQ_ENS  = 26;
    localparam int unsigned W_FIQ_ENC  = 27;

    localparam logic [DATA_W-1:0] RST_OSC    = 32'h0100_0048;
    localparam logic [DATA_W-1:0] RST_AUX    = 32'h0007_FEFF;
    localparam logic [DATA_W-1:0] RST_MEMCFG = 32'h0001_1122;
    localparam logic [DATA_W-1:0] RST_INIT   = 32'h0000_0112;

    localparam int unsigned CTRL_LED_BIT   = 0;
    localparam int unsigned CTRL_REMAP_BIT = 2;

    typedef enum logic { KEY_LOCKED, KEY_OPEN } key_state_e;
    typedef enum logic { MAP_FLASH, MAP_RAM } map_state_e;

    // module description table entry, computed from its index
    function automatic logic [7:0] desc_byte(input logic [6:0] idx);
        logic [15:0] prod;
        prod = {9'd0, idx} * 16'd37;
        return prod[7:0] ^ 8'hC3;
    endfunction

endpackage

// File: rtl/cm_key_lock.sv
module cm_key_lock
    import cm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_in,
    output logic [KEY_W-1:0] key_q,
    output logic             bank_open
);

    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_LOCKED: if (key_wr && key_in == UNLOCK_KEY) state_d = KEY_OPEN;   // unlock
            KEY_OPEN:   if (key_wr && key_in != UNLOCK_KEY) state_d = KEY_LOCKED; // relock
            default:    state_d = KEY_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KEY_LOCKED;
            key_q   <= '0;
        end else begin
            state_q <= state_d;
            if (key_wr) key_q <= key_in;
        end
    end

    always_comb begin
        bank_open = (state_q == KEY_OPEN);
    end

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_in == UNLOCK_KEY) |=> bank_open); // R1
    AST_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_in != UNLOCK_KEY) |=> !bank_open); // R1

endmodule

// File: rtl/cm_remap_fsm.sv
module cm_remap_fsm
    import cm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic want_ram,
    output logic remap_ram
);

    map_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MAP_FLASH: if (ctrl_wr && want_ram)  state_d = MAP_RAM;   // to_ram
            MAP_RAM:   if (ctrl_wr && !want_ram) state_d = MAP_FLASH; // to_flash
            default:   state_d = MAP_FLASH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MAP_FLASH;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MAP_RAM: remap_ram = 1'b1;
            default: remap_ram = 1'b0;
        endcase
    end

    AST_REMAP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (remap_ram == $past(want_ram))); // R6
    AST_REMAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(remap_ram)); // R6

endmodule

// File: rtl/cm_irq_unit.sv
module cm_irq_unit
    import cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_set,
    input  logic              lvl_clr,
    input  logic              irq_en_set,
    input  logic              irq_en_clr,
    input  logic              fiq_en_set,
    input  logic              fiq_en_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic              level_q,
    output logic [DATA_W-1:0] irq_en_q,
    output logic [DATA_W-1:0] fiq_en_q,
    output logic              irq_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q  <= 1'b0;
            irq_en_q <= '0;
            fiq_en_q <= '0;
        end else begin
            if (lvl_set && wdata[0])      level_q <= 1'b1;
            else if (lvl_clr && wdata[0]) level_q <= 1'b0;
            if (irq_en_set)      irq_en_q <= irq_en_q | wdata;
            else if (irq_en_clr) irq_en_q <= irq_en_q & ~wdata;
            if (fiq_en_set)      fiq_en_q <= fiq_en_q | wdata;
            else if (fiq_en_clr) fiq_en_q <= fiq_en_q & ~wdata;
        end
    end

    always_comb begin
        irq_out = level_q & (irq_en_q[0] | fiq_en_q[0]);
    end

    AST_IRQ_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> level_q); // R10
    AST_LVL_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_clr && wdata[0]) |=> !irq_out); // R8

endmodule

// File: rtl/cm_ctrl_bank.sv
module cm_ctrl_bank
    import cm_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              remap_ram,
    output logic              led_on,
    output logic              core_irq
);

    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned IDX_W  = 7;

    logic [WORD_W-1:0] word;
    logic              in_window;
    logic              wr;

    logic [DATA_W-1:0] osc_q, aux_q, memcfg_q, init_q, ctrl_q, flag_q, nvf_q;
    logic [KEY_W-1:0]  key_q;
    logic              bank_open;
    logic              level_q;
    logic [DATA_W-1:0] irq_en_q, fiq_en_q;
    logic [IDX_W-1:0]  tbl_idx;

    always_comb begin
        word      = bus_addr[ADDR_W-1:2];
        in_window = bus_addr[ADDR_W-1];
        wr        = bus_we && !in_window;
        tbl_idx   = IDX_W'(word);
    end

    function automatic logic hit(input logic [WORD_W-1:0] w, input int unsigned idx);
        return w == WORD_W'(idx);
    endfunction

    cm_key_lock u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (wr && hit(word, W_KEY)),
        .key_in    (bus_wdata[KEY_W-1:0]),
        .key_q     (key_q),
        .bank_open (bank_open)
    );

    cm_remap_fsm u_remap (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr && hit(word, W_CTRL)),
        .want_ram  (bus_wdata[CTRL_REMAP_BIT]),
        .remap_ram (remap_ram)
    );

    cm_irq_unit u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_set    (wr && hit(word, W_LVL_SET)),
        .lvl_clr    (wr && hit(word, W_LVL_CLR)),
        .irq_en_set (wr && hit(word, W_IRQ_ENS)),
        .irq_en_clr (wr && hit(word, W_IRQ_ENC)),
        .fiq_en_set (wr && hit(word, W_FIQ_ENS)),
        .fiq_en_clr (wr && hit(word, W_FIQ_ENC)),
        .wdata      (bus_wdata),
        .level_q    (level_q),
        .irq_en_q   (irq_en_q),
        .fiq_en_q   (fiq_en_q),
        .irq_out    (core_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_q    <= RST_OSC;
            aux_q    <= RST_AUX;
            memcfg_q <= RST_MEMCFG;
            init_q   <= RST_INIT;
            ctrl_q   <= '0;
            flag_q   <= '0;
            nvf_q    <= '0;
        end else if (wr) begin
            if (hit(word, W_OSC) && bank_open) osc_q <= bus_wdata;
            if (hit(word, W_AUX) && bank_open) aux_q <= bus_wdata;
            if (hit(word, W_MEMCFG))   memcfg_q <= bus_wdata;
            if (hit(word, W_INIT))     init_q   <= bus_wdata;
            if (hit(word, W_CTRL))     ctrl_q   <= bus_wdata;
            if (hit(word, W_FLAG_SET)) flag_q   <= flag_q | bus_wdata;
            if (hit(word, W_FLAG_CLR)) flag_q   <= flag_q & ~bus_wdata;
            if (hit(word, W_NVF_SET))  nvf_q    <= nvf_q | bus_wdata;
            if (hit(word, W_NVF_CLR))  nvf_q    <= nvf_q & ~bus_wdata;
        end
    end

    always_comb begin
        led_on = ctrl_q[CTRL_LED_BIT];
    end

    always_comb begin
        bus_rdata = '0;
        if (in_window) begin
            bus_rdata = {24'd0, desc_byte(tbl_idx)};
        end else begin
            unique case (int'(word))
                W_OSC:      bus_rdata = osc_q;
                W_CTRL:     bus_rdata = ctrl_q;
                W_KEY:      bus_rdata = {15'd0, !bank_open, key_q};
                W_AUX:      bus_rdata = aux_q;
                W_MEMCFG:   bus_rdata = memcfg_q;
                W_INIT:     bus_rdata = init_q;
                W_FLAG_SET: bus_rdata = flag_q;
                W_NVF_SET:  bus_rdata = nvf_q;
                W_IRQ_STAT: bus_rdata = {31'd0, level_q} & irq_en_q;
                W_IRQ_RAW,
                W_LVL_SET,
                W_FIQ_RAW:  bus_rdata = {31'd0, level_q};
                W_IRQ_ENS:  bus_rdata = irq_en_q;
                W_FIQ_STAT: bus_rdata = {31'd0, level_q} & fiq_en_q;
                W_FIQ_ENS:  bus_rdata = fiq_en_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    AST_OSC_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bank_open) |-> $stable(osc_q)); // R2
    AST_AUX_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bank_open) |-> $stable(aux_q)); // R2
    AST_FLAG_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit(word, W_FLAG_SET)) |=> ((flag_q & $past(bus_wdata)) == $past(bus_wdata))); // R4
    AST_NVF_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit(word, W_NVF_CLR)) |=> ((nvf_q & $past(bus_wdata)) == '0)); // R5
    AST_WINDOW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && in_window) |=> ($stable(flag_q) && $stable(ctrl_q) && $stable(memcfg_q))); // R7

endmodule

// File: tb/cm_ctrl_bank_tb.sv
module cm_ctrl_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        remap_ram, led_on, core_irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    cm_ctrl_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .remap_ram (remap_ram),
        .led_on    (led_on),
        .core_irq  (core_irq)
    );

    function automatic logic [7:0] exp_tbl(input int i);
        int p;
        p = (i * 37) % 256;
        return 8'(p) ^ 8'hC3;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [8:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic t_reset;
        rd_check("R3 osc", 9'h004, 32'h0100_0048);
        rd_check("R3 aux", 9'h01C, 32'h0007_FEFF);
        rd_check("R3 memcfg", 9'h020, 32'h0001_1122);
        rd_check("R3 init", 9'h024, 32'h0000_0112);
        rd_check("R3 ctrl", 9'h00C, 32'h0);
        rd_check("R1 key reset", 9'h014, 32'h0001_0000);
        check("R6 remap reset", {31'd0, remap_ram}, 32'd0);
        check("R10 irq reset", {31'd0, core_irq}, 32'd0);
    endtask

    task automatic t_lock;
        wr(9'h004, 32'h1111_2222);
        rd_check("R2 osc locked", 9'h004, 32'h0100_0048);
        wr(9'h014, 32'h1234_A05F);
        rd_check("R1 key open", 9'h014, 32'h0000_A05F);
        wr(9'h004, 32'hDEAD_BEEF);
        rd_check("R2 osc open", 9'h004, 32'hDEAD_BEEF);
        wr(9'h01C, 32'h0000_0ABC);
        rd_check("R2 aux open", 9'h01C, 32'h0000_0ABC);
        wr(9'h014, 32'h0000_A05E);
        rd_check("R1 key relock", 9'h014, 32'h0001_A05E);
        wr(9'h01C, 32'h5555_5555);
        rd_check("R2 aux locked", 9'h01C, 32'h0000_0ABC);
        wr(9'h020, 32'h0000_0033);
        rd_check("R3 memcfg write", 9'h020, 32'h0000_0033);
        wr(9'h024, 32'h0000_0044);
        rd_check("R3 init write", 9'h024, 32'h0000_0044);
    endtask

    task automatic t_flags;
        wr(9'h030, 32'h0000_F0F0);
        wr(9'h030, 32'h0000_000F);
        rd_check("R4 flag set", 9'h030, 32'h0000_F0FF);
        wr(9'h034, 32'h0000_F000);
        rd_check("R4 flag clr", 9'h030, 32'h0000_00FF);
        wr(9'h038, 32'h8000_0001);
        rd_check("R5 nv set", 9'h038, 32'h8000_0001);
        wr(9'h03C, 32'h0000_0001);
        rd_check("R5 nv clr", 9'h038, 32'h8000_0000);
        rd_check("R5 flags independent", 9'h030, 32'h0000_00FF);
    endtask

    task automatic t_ctrl;
        wr(9'h00C, 32'h0000_0005);
        check("R6 remap ram", {31'd0, remap_ram}, 32'd1);
        check("R6 led on", {31'd0, led_on}, 32'd1);
        rd_check("R6 ctrl read", 9'h00C, 32'h0000_0005);
        wr(9'h00C, 32'h0000_0001);
        check("R6 remap flash", {31'd0, remap_ram}, 32'd0);
        check("R6 led kept", {31'd0, led_on}, 32'd1);
        wr(9'h00C, 32'h0000_0000);
        check("R6 led off", {31'd0, led_on}, 32'd0);
    endtask

    task automatic t_window;
        rd_check("R7 first", 9'h100, {24'd0, exp_tbl(64)});
        rd_check("R7 last", 9'h1FC, {24'd0, exp_tbl(127)});
        rd_check("R7 unaligned", 9'h1A1, {24'd0, exp_tbl(104)});
        wr(9'h130, 32'hFFFF_FFFF);
        rd_check("R7 write ignored", 9'h130, {24'd0, exp_tbl(76)});
        rd_check("R7 flags untouched", 9'h030, 32'h0000_00FF);
    endtask

    task automatic t_irq;
        wr(9'h050, 32'h0000_0002);
        rd_check("R8 only bit0", 9'h044, 32'd0);
        wr(9'h050, 32'h0000_0001);
        rd_check("R8 level read", 9'h050, 32'd1);
        rd_check("R8 fiq raw", 9'h064, 32'd1);
        check("R10 no enable", {31'd0, core_irq}, 32'd0);
        wr(9'h048, 32'h0000_0001);
        check("R10 irq on", {31'd0, core_irq}, 32'd1);
        rd_check("R9 irq stat", 9'h040, 32'd1);
        rd_check("R9 fiq stat off", 9'h060, 32'd0);
        wr(9'h04C, 32'h0000_0001);
        check("R10 irq off", {31'd0, core_irq}, 32'd0);
        wr(9'h068, 32'h0000_0003);
        rd_check("R9 fiq en read", 9'h068, 32'd3);
        rd_check("R9 fiq stat", 9'h060, 32'd1);
        check("R10 fiq path", {31'd0, core_irq}, 32'd1);
        wr(9'h054, 32'h0000_0001);
        check("R10 level clr", {31'd0, core_irq}, 32'd0);
        rd_check("R8 level clr", 9'h044, 32'd0);
        wr(9'h06C, 32'h0000_0002);
        rd_check("R9 fiq en clr", 9'h068, 32'd1);
    endtask

    task automatic t_unimpl;
        rd_check("R11 word0", 9'h000, 32'd0);
        rd_check("R11 word40", 9'h0A0, 32'd0);
        wr(9'h0A0, 32'hFFFF_FFFF);
        wr(9'h000, 32'hFFFF_FFFF);
        rd_check("R11 flags kept", 9'h030, 32'h0000_00FF);
        rd_check("R11 ctrl kept", 9'h00C, 32'd0);
        rd_check("R11 word40 still zero", 9'h0A0, 32'd0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_lock();
                t_flags();
                t_ctrl();
                t_window();
                t_irq();
                t_unimpl();
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule